// File: doc/BRIEF.md
# Dual-Slot Power Fault Supervisor

This block controls the switch enables for two card slots that are powered on and off independently. Each slot has its own power request input. The analog side feeds the block digital comparator flags: one overcurrent flag for each of the slot's four supplies, and one undervoltage flag for each of three of those supplies. Each slot has an active-low fault output.

A fault flag must stay present for longer than the slot's programmed filter time before it has any effect. Short noise spikes are therefore ignored. When a fault persists, the block latches that slot off and pulls its fault line low. The other slot keeps running. The latch is released only by dropping that slot's request.

A main-supply-good input keeps both slots idle until it is asserted. A mode input turns undervoltage monitoring off, so that only overcurrent can trip a slot.

Top module: `dual_slot_power_supervisor`

## Requirements
- R1: A fault on one slot leaves the enables and the fault output of the other slot unchanged.
- R2: An overcurrent flag on any of a slot's four supplies counts as a fault for that slot, whether or not the slot is enabled. Flag bit `oc_flag[4*s+k]` is supply k of slot s.
- R3: While a slot is enabled and `uv_off` is 0, any of its undervoltage flags counts as a fault. Flag bit `uv_flag[3*s+k]` is supply k of slot s.
- R4: A latched fault drives that slot's `fault_n` low and all four of its enables low.
- R5: A fault latches only after it has been present on D+1 consecutive clock edges, where D is the slot's `delay_cfg` field (bits `[DLY_W*s +: DLY_W]`). Any cycle without a qualifying flag restarts the count from zero.
- R6: A latched fault clears, and `fault_n` returns high, on the third clock edge after the slot's request goes low. A request that stays high never clears it.
- R7: From the third clock edge after `main_ok` goes low, and for as long as it stays low:
  - both slots are disabled;
  - their fault latches are cleared and `fault_n` is high;
  - request edges and fault flags have no effect.
- R8: A slot's enables assert on the third clock edge after a low-to-high change of its request. A request that is already high when a latch clears or when `main_ok` returns does not enable the slot.
- R9: With `uv_off` at 1, undervoltage flags never cause a fault.
- R10: Undervoltage flags on a slot whose enables are off never cause a fault.
- R11: While reset is asserted, and after reset until a request edge arrives, all enables are low and both `fault_n` outputs are high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| main_ok | input | 1 | Main supply above its good threshold |
| uv_off | input | 1 | 1 disables undervoltage monitoring |
| slot_req | input | NSLOT | Per-slot power request, asynchronous |
| oc_flag | input | NSLOT*4 | Overcurrent comparator flags |
| uv_flag | input | NSLOT*3 | Undervoltage comparator flags |
| delay_cfg | input | NSLOT*DLY_W | Per-slot filter length D |
| sw_en | output | NSLOT*4 | Per-supply switch enables |
| fault_n | output | NSLOT | Per-slot active-low fault |

## Verification
The bench builds the block with two slots and a 4-bit delay field, and programs the two slots differently:

- **Slot 0 uses D=3.** A three-cycle undervoltage burst, a one-cycle gap and a second three-cycle burst together show that the counter restarts after a gap.
- **Slot 1 uses D=0.** Its one-cycle trip makes cross-slot isolation easy to see.

Holding one slot latched while the other is re-enabled exercises the per-slot clear path. A supply-good dropout followed by recovery with the request still high exercises the fresh-edge rule.

// File: rtl/psup_pkg.sv
package psup_pkg;
  localparam int SUP_N = 4;
  localparam int UV_N  = 3;

  typedef enum logic [1:0] {
    SLOT_OFF  = 2'd0,
    SLOT_ON   = 2'd1,
    SLOT_TRIP = 2'd2
  } slot_st_e;
endpackage

// File: rtl/psup_sync.sv
module psup_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg_q [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) stg_q[i] <= '0;
    end else begin
      stg_q[0] <= d;
      for (int i = 1; i < STAGES; i++) stg_q[i] <= stg_q[i-1];
    end
  end

  assign q = stg_q[STAGES-1];
endmodule

// File: rtl/psup_filter.sv
module psup_filter #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         hit,
  input  logic [W-1:0] limit,
  output logic         trip
);
  logic [W-1:0] cnt_q, cnt_d;
  logic         at_lim;

  assign at_lim = (cnt_q >= limit);
  assign trip   = hit && !clr && at_lim;

  always_comb begin
    cnt_d = cnt_q;
    if (clr || !hit || at_lim) cnt_d = '0;
    else                       cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  // R5: a nonzero count implies an uninterrupted qualifying flag on the last edge
  p_count_needs_hit_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q != '0) |-> $past(hit && !clr));
endmodule

// File: rtl/psup_slot.sv
module psup_slot
  import psup_pkg::*;
#(
  parameter int DLY_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             hold,
  input  logic             req_s,
  input  logic             uv_off,
  input  logic [SUP_N-1:0] oc,
  input  logic [UV_N-1:0]  uv,
  input  logic [DLY_W-1:0] limit,
  output logic [SUP_N-1:0] en,
  output logic             fault_n
);
  slot_st_e st_q, st_d;
  logic     req_d_q;
  logic     hit, clr, trip, req_rise;

  assign hit      = (|oc) || ((st_q == SLOT_ON) && !uv_off && (|uv));
  assign clr      = hold || (st_q == SLOT_TRIP);
  assign req_rise = req_s && !req_d_q;

  psup_filter #(.W(DLY_W)) u_filt (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (clr),
    .hit   (hit),
    .limit (limit),
    .trip  (trip)
  );

  always_comb begin
    st_d = st_q;
    if (hold) begin
      st_d = SLOT_OFF;
    end else begin
      case (st_q)
        SLOT_OFF:  if (trip) st_d = SLOT_TRIP;
                   else if (req_rise) st_d = SLOT_ON;
        SLOT_ON:   if (trip) st_d = SLOT_TRIP;
                   else if (!req_s) st_d = SLOT_OFF;
        SLOT_TRIP: if (!req_s) st_d = SLOT_OFF;
        default:   st_d = SLOT_OFF;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= SLOT_OFF;
      req_d_q <= 1'b0;
    end else begin
      st_q    <= st_d;
      req_d_q <= req_s;
    end
  end

  assign en      = {SUP_N{st_q == SLOT_ON}};
  assign fault_n = (st_q != SLOT_TRIP);

  // R7: supply lockout forces the slot idle on the next edge
  p_hold_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    hold |=> (st_q == SLOT_OFF));
  // R5: the latch sets only when the filter has expired
  p_trip_from_filter_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(st_q == SLOT_TRIP) |-> $past(trip));
  // R6: the latch clears only after a low request or a lockout
  p_clear_on_low_req_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(st_q == SLOT_TRIP) |-> ($past(!req_s) || $past(hold)));
  // R8: enabling needs a fresh rising edge of the request
  p_on_needs_edge_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(st_q == SLOT_ON) |-> $past(req_s && !req_d_q));
endmodule

// File: rtl/dual_slot_power_supervisor.sv
module dual_slot_power_supervisor
  import psup_pkg::*;
#(
  parameter int NSLOT = 2,
  parameter int DLY_W = 8
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   main_ok,
  input  logic                   uv_off,
  input  logic [NSLOT-1:0]       slot_req,
  input  logic [NSLOT*SUP_N-1:0] oc_flag,
  input  logic [NSLOT*UV_N-1:0]  uv_flag,
  input  logic [NSLOT*DLY_W-1:0] delay_cfg,
  output logic [NSLOT*SUP_N-1:0] sw_en,
  output logic [NSLOT-1:0]       fault_n
);
  logic             rst_q;
  logic             ok_s;
  logic             hold;
  logic [NSLOT-1:0] req_s;

  psup_sync #(.W(1), .STAGES(2)) u_rst_sync (
    .clk(clk), .rst_n(rst_n), .d(1'b1), .q(rst_q)
  );

  psup_sync #(.W(1), .STAGES(2)) u_ok_sync (
    .clk(clk), .rst_n(rst_q), .d(main_ok), .q(ok_s)
  );

  psup_sync #(.W(NSLOT), .STAGES(2)) u_req_sync (
    .clk(clk), .rst_n(rst_q), .d(slot_req), .q(req_s)
  );

  assign hold = !ok_s;

  for (genvar s = 0; s < NSLOT; s++) begin : g_slot
    psup_slot #(.DLY_W(DLY_W)) u_slot (
      .clk     (clk),
      .rst_n   (rst_q),
      .hold    (hold),
      .req_s   (req_s[s]),
      .uv_off  (uv_off),
      .oc      (oc_flag[SUP_N*s +: SUP_N]),
      .uv      (uv_flag[UV_N*s +: UV_N]),
      .limit   (delay_cfg[DLY_W*s +: DLY_W]),
      .en      (sw_en[SUP_N*s +: SUP_N]),
      .fault_n (fault_n[s])
    );
  end
endmodule

// File: tb/dual_slot_power_supervisor_test.sv
module dual_slot_power_supervisor_test;
  localparam int NSLOT = 2;
  localparam int DLY_W = 4;
  localparam int NVEC  = 16;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       main_ok = 1'b1;
  logic       uv_off = 1'b0;
  logic [1:0] slot_req = '0;
  logic [7:0] oc_flag = '0;
  logic [5:0] uv_flag = '0;
  logic [7:0] delay_cfg = {4'd0, 4'd3};
  logic [7:0] sw_en;
  logic [1:0] fault_n;

  int errors = 0;
  int checks = 0;

  always #5 clk = ~clk;

  dual_slot_power_supervisor #(.NSLOT(NSLOT), .DLY_W(DLY_W)) uut (
    .clk(clk), .rst_n(rst_n), .main_ok(main_ok), .uv_off(uv_off),
    .slot_req(slot_req), .oc_flag(oc_flag), .uv_flag(uv_flag),
    .delay_cfg(delay_cfg), .sw_en(sw_en), .fault_n(fault_n)
  );

  // {req[1:0], oc[7:0], uv[5:0], uv_off, wait[3:0], exp_en[1:0], exp_fn[1:0]}
  localparam logic [24:0] VEC [NVEC] = '{
    {2'b00, 8'h00, 6'b000000, 1'b0, 4'd4, 2'b00, 2'b11}, // R11 idle
    {2'b11, 8'h00, 6'b000000, 1'b0, 4'd3, 2'b11, 2'b11}, // R8 both on
    {2'b11, 8'h40, 6'b000000, 1'b0, 4'd1, 2'b01, 2'b01}, // R2 R1 slot1 oc
    {2'b11, 8'h00, 6'b000001, 1'b0, 4'd3, 2'b01, 2'b01}, // R5 short burst
    {2'b11, 8'h00, 6'b000000, 1'b0, 4'd1, 2'b01, 2'b01}, // R5 gap
    {2'b11, 8'h00, 6'b000001, 1'b0, 4'd3, 2'b01, 2'b01}, // R5 restart
    {2'b11, 8'h00, 6'b000001, 1'b0, 4'd1, 2'b00, 2'b00}, // R3 R4 slot0 uv trips
    {2'b01, 8'h00, 6'b000000, 1'b0, 4'd3, 2'b00, 2'b10}, // R6 slot1 clears
    {2'b11, 8'h00, 6'b000000, 1'b0, 4'd3, 2'b10, 2'b10}, // R6 R8 slot1 re-on
    {2'b10, 8'h00, 6'b000000, 1'b0, 4'd3, 2'b10, 2'b11}, // R6 slot0 clears
    {2'b10, 8'h00, 6'b000111, 1'b0, 4'd6, 2'b10, 2'b11}, // R10 uv on off slot
    {2'b11, 8'h00, 6'b000000, 1'b0, 4'd3, 2'b11, 2'b11}, // R8 slot0 on
    {2'b11, 8'h00, 6'b111111, 1'b1, 4'd6, 2'b11, 2'b11}, // R9 uv masked
    {2'b11, 8'h00, 6'b111111, 1'b0, 4'd1, 2'b01, 2'b01}, // R9 R3 unmasked
    {2'b11, 8'h00, 6'b000000, 1'b0, 4'd1, 2'b01, 2'b01}, // R5 slot0 restarts
    {2'b11, 8'h08, 6'b000000, 1'b0, 4'd4, 2'b00, 2'b00}  // R2 slot0 oc bit3
  };

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(input string tag, input logic [1:0] exp_en, input logic [1:0] exp_fn);
    logic [7:0] want;
    want = {{4{exp_en[1]}}, {4{exp_en[0]}}};
    checks++;
    if (sw_en !== want || fault_n !== exp_fn) begin
      errors++;
      $display("FAIL %s: sw_en=%b fault_n=%b expected sw_en=%b fault_n=%b",
               tag, sw_en, fault_n, want, exp_fn);
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #1 chk("R11 in reset", 2'b00, 2'b11);
    @(negedge clk);
    rst_n = 1'b1;
    step(6);
    chk("R11 after reset", 2'b00, 2'b11);

    for (int i = 0; i < NVEC; i++) begin
      slot_req = VEC[i][24:23];
      oc_flag  = VEC[i][22:15];
      uv_flag  = VEC[i][14:9];
      uv_off   = VEC[i][8];
      step(int'(VEC[i][7:4]));
      chk($sformatf("vector %0d", i), VEC[i][3:2], VEC[i][1:0]);
    end
    oc_flag = '0;

    // R7: supply lockout clears both latches
    main_ok = 1'b0;
    step(3);
    chk("R7 lockout clears", 2'b00, 2'b11);
    oc_flag = 8'hFF;
    uv_flag = 6'b111111;
    step(5);
    chk("R7 flags ignored", 2'b00, 2'b11);
    oc_flag = '0;
    uv_flag = '0;
    slot_req = 2'b00;
    step(3);
    slot_req = 2'b11;
    step(3);
    chk("R7 request ignored", 2'b00, 2'b11);

    // R8: recovery with request already high needs a fresh edge
    main_ok = 1'b1;
    step(5);
    chk("R8 no fresh edge", 2'b00, 2'b11);
    slot_req = 2'b00;
    step(3);
    slot_req = 2'b11;
    step(2);
    chk("R8 not yet on", 2'b00, 2'b11);
    step(1);
    chk("R8 fresh edge", 2'b11, 2'b11);

    // R11: asynchronous reset takes effect at once
    rst_n = 1'b0;
    #1 chk("R11 async reset", 2'b00, 2'b11);
    step(2);
    rst_n = 1'b1;

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule